// File: doc/BRIEF.md
# PCI Bridge Error Reporting Unit

This unit sits in a PCI bridge and turns single-cycle error event strobes into two things. The first is a set of sticky status flags that software reads and then clears. The second is active-low request pulses for the system error line, the parity error line and the processor init line.

Software uses a byte-wide configuration port to reach two registers. One is an error command register holding per-event enables. The other is an error status register whose flags are cleared by writing 1 to them. Each per-event system error enable acts only while the global system-error enable input is high. The parity error enable acts only while the global parity-checking enable input is high.

A host shutdown cycle is recorded in the status register. When the shutdown-init select input is high, the shutdown cycle also requests an init pulse.

Top module: `bridge_err_unit`

## Requirements
- R1: After reset, both registers read 8'h00 and `serr_n`, `perr_n` and `init_n` are high.
- R2: A write to address 8'h70 loads the command register. A read of address 8'h70 returns it. Bits 2:0 always read 0. Bit 7 enables target abort, bit 6 enables target-reported write parity, bit 5 enables read data parity, bit 4 enables address parity and bit 3 enables the parity error line.
- R3: The status register at address 8'h71 sets and holds a flag when the matching event strobe is high. Bit 6 is set by `ev_wr_perr`, bit 5 by `ev_rd_par`, bit 4 by `ev_addr_par` and bit 0 by `ev_shutdown`. A flag is visible on the first read after the strobe's clock edge.
- R4: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. Status bits 7 and 3:1 always read 0.
- R5: When an event strobe and a write-1-to-clear hit the same status bit in the same cycle, the bit stays set.
- R6: `serr_n` is low for the one clock that follows a cycle in which all of these hold: an event among `ev_tabort`, `ev_wr_perr`, `ev_rd_par` and `ev_addr_par` is high, its command bit is set, and `glb_serr_en` is high. If either enable is low, `serr_n` stays high.
- R7: `perr_n` is low for the one clock that follows a cycle in which all of these hold: `ev_rd_par` or `ev_tgt_par` (received write data parity) is high, command bit 3 is set, and `glb_par_en` is high. If either enable is low, `perr_n` stays high.
- R8: `init_n` is low for the one clock that follows `ev_shutdown` when `shut_init_en` is high. When `shut_init_en` is low, `init_n` stays high.
- R9: `ev_tabort` and `ev_tgt_par` leave the status register unchanged.
- R10: Reads of any address other than 8'h70 and 8'h71 return 8'h00, and writes to other addresses change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data (combinational) |
| glb_serr_en | input | 1 | Global system error enable |
| glb_par_en | input | 1 | Global parity checking enable |
| shut_init_en | input | 1 | Allows a shutdown cycle to request init |
| ev_tabort | input | 1 | Target abort received while bridge is master |
| ev_wr_perr | input | 1 | Target reported parity error on written data |
| ev_rd_par | input | 1 | Bad parity on read data, bridge is master |
| ev_addr_par | input | 1 | Bad address/command parity from another master |
| ev_tgt_par | input | 1 | Bad parity on data another master writes to the bridge |
| ev_shutdown | input | 1 | Host shutdown cycle detected |
| serr_n | output | 1 | System error request, active low |
| perr_n | output | 1 | Parity error request, active low |
| init_n | output | 1 | Init request, active low |

## Verification
The bench clears a status bit in the same cycle that its event fires. A design that gave the clear priority would lose the flag.

It toggles each global enable separately from the local command bits. A design that ignored the gating would pulse `serr_n` or `perr_n` when it should stay silent.

It also checks that each pulse lasts exactly one clock, and that reserved status bits stay 0 after writing all ones. Target aborts and target-side write parity errors must leave the status untouched, and a design that mapped them into a status bit would fail that check.

// File: rtl/bridge_err_unit.sv
module bridge_err_unit #(
  parameter logic [7:0] CMD_ADDR = 8'h70,
  parameter logic [7:0] STS_ADDR = 8'h71
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       glb_serr_en,
  input  logic       glb_par_en,
  input  logic       shut_init_en,
  input  logic       ev_tabort,
  input  logic       ev_wr_perr,
  input  logic       ev_rd_par,
  input  logic       ev_addr_par,
  input  logic       ev_tgt_par,
  input  logic       ev_shutdown,
  output logic       serr_n,
  output logic       perr_n,
  output logic       init_n
);
  localparam logic [7:0] CMD_MASK = 8'hF8;
  localparam logic [7:0] STS_MASK = 8'h71;

  logic [7:0] cmd_q, sts_q;
  logic [7:0] sts_set, sts_clr;
  logic       serr_req, perr_req, init_req;

  assign sts_set  = {1'b0, ev_wr_perr, ev_rd_par, ev_addr_par, 3'b000, ev_shutdown};
  assign sts_clr  = (cfg_wr && cfg_addr == STS_ADDR) ? cfg_wdata : 8'h00;

  assign serr_req = glb_serr_en & ((ev_tabort & cmd_q[7]) | (ev_wr_perr & cmd_q[6]) |
                                   (ev_rd_par & cmd_q[5]) | (ev_addr_par & cmd_q[4]));
  assign perr_req = glb_par_en & cmd_q[3] & (ev_rd_par | ev_tgt_par);
  assign init_req = shut_init_en & ev_shutdown;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= 8'h00;
      sts_q  <= 8'h00;
      serr_n <= 1'b1;
      perr_n <= 1'b1;
      init_n <= 1'b1;
    end else begin
      if (cfg_wr && cfg_addr == CMD_ADDR)
        cmd_q <= cfg_wdata & CMD_MASK;
      sts_q  <= ((sts_q & ~sts_clr) | sts_set) & STS_MASK;
      serr_n <= ~serr_req;
      perr_n <= ~perr_req;
      init_n <= ~init_req;
    end
  end

  always_comb begin
    case (cfg_addr)
      CMD_ADDR: cfg_rdata = cmd_q;
      STS_ADDR: cfg_rdata = sts_q;
      default:  cfg_rdata = 8'h00;
    endcase
  end
endmodule

module bridge_err_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cmd_q,
  input logic [7:0] sts_q,
  input logic       cfg_wr,
  input logic [7:0] cfg_addr,
  input logic [7:0] cfg_wdata,
  input logic       glb_serr_en,
  input logic       shut_init_en,
  input logic       ev_tabort,
  input logic       ev_wr_perr,
  input logic       ev_rd_par,
  input logic       ev_addr_par,
  input logic       ev_shutdown,
  input logic       serr_n,
  input logic       init_n
);
  p_rsvd_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q & 8'h8E) == 8'h00 && cmd_q[2:0] == 3'b000);

  p_shutdown_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_shutdown |=> sts_q[0]);

  p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr_perr && cfg_wr && cfg_addr == 8'h71 && cfg_wdata[6]) |=> sts_q[6]);

  p_serr_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n |-> $past(glb_serr_en));

  p_serr_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tabort && cmd_q[7] && glb_serr_en) |=> !serr_n);

  p_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_shutdown && shut_init_en) |=> !init_n);

  p_init_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !init_n |-> $past(ev_shutdown && shut_init_en));

  p_tabort_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tabort && !ev_wr_perr && !ev_rd_par && !ev_addr_par && !ev_shutdown && !cfg_wr)
      |=> $stable(sts_q));
endmodule

bind bridge_err_unit bridge_err_unit_chk u_chk (.*);

// File: tb/tb_bridge_err_unit.sv
module tb_bridge_err_unit;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0;
  logic [7:0] cfg_addr = 0, cfg_wdata = 0, cfg_rdata;
  logic glb_serr_en = 0, glb_par_en = 0, shut_init_en = 0;
  logic ev_tabort = 0, ev_wr_perr = 0, ev_rd_par = 0, ev_addr_par = 0, ev_tgt_par = 0, ev_shutdown = 0;
  logic serr_n, perr_n, init_n;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bridge_err_unit dut (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
  endtask

  // e = {tabort, wr_perr, rd_par, addr_par, tgt_par, shutdown}; returns {serr_n,perr_n,init_n}
  task automatic fire(input logic [5:0] e, output logic [2:0] o);
    @(negedge clk);
    {ev_tabort, ev_wr_perr, ev_rd_par, ev_addr_par, ev_tgt_par, ev_shutdown} = e;
    @(negedge clk);
    {ev_tabort, ev_wr_perr, ev_rd_par, ev_addr_par, ev_tgt_par, ev_shutdown} = '0;
    o = {serr_n, perr_n, init_n};
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(8'h70, d); check("R1 cmd reset", d, 8'h00);
    rd(8'h71, d); check("R1 sts reset", d, 8'h00);
    check("R1 outputs idle", {5'b0, serr_n, perr_n, init_n}, 8'h07);
  endtask

  task automatic t_cmd_rw;
    logic [7:0] d;
    wr(8'h70, 8'hFF); rd(8'h70, d); check("R2 cmd all ones", d, 8'hF8);
    wr(8'h70, 8'h5A); rd(8'h70, d); check("R2 cmd pattern", d, 8'h58);
  endtask

  task automatic t_status;
    logic [2:0] o; logic [7:0] d;
    fire(6'b010000, o); rd(8'h71, d); check("R3 wr_perr flag", d, 8'h40);
    fire(6'b001000, o); rd(8'h71, d); check("R3 rd_par flag", d, 8'h60);
    fire(6'b000101, o); rd(8'h71, d); check("R3 addr/shutdown flags", d, 8'h71);
    repeat (3) @(negedge clk);
    rd(8'h71, d); check("R3 flags sticky", d, 8'h71);
  endtask

  task automatic t_w1c;
    logic [7:0] d;
    wr(8'h71, 8'h00); rd(8'h71, d); check("R4 write zero keeps", d, 8'h71);
    wr(8'h71, 8'h20); rd(8'h71, d); check("R4 clear bit5", d, 8'h51);
    wr(8'h71, 8'hFF); rd(8'h71, d); check("R4 clear all, reserved 0", d, 8'h00);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    @(negedge clk); ev_wr_perr = 1; cfg_wr = 1; cfg_addr = 8'h71; cfg_wdata = 8'h40;
    @(negedge clk); ev_wr_perr = 0; cfg_wr = 0;
    rd(8'h71, d); check("R5 event beats clear", d, 8'h40);
    wr(8'h71, 8'hFF);
  endtask

  task automatic t_serr;
    logic [2:0] o;
    wr(8'h70, 8'hF0); glb_serr_en = 1;
    fire(6'b100000, o); check("R6 serr on abort", {7'b0, o[2]}, 8'h00);
    @(negedge clk); check("R6 serr one cycle", {7'b0, serr_n}, 8'h01);
    fire(6'b000100, o); check("R6 serr on addr parity", {7'b0, o[2]}, 8'h00);
    glb_serr_en = 0;
    fire(6'b110100, o); check("R6 global gate off", {7'b0, o[2]}, 8'h01);
    glb_serr_en = 1; wr(8'h70, 8'h70);
    fire(6'b100000, o); check("R6 abort local bit off", {7'b0, o[2]}, 8'h01);
    fire(6'b010000, o); check("R6 serr on wr_perr", {7'b0, o[2]}, 8'h00);
    wr(8'h71, 8'hFF);
  endtask

  task automatic t_perr;
    logic [2:0] o;
    wr(8'h70, 8'h08); glb_par_en = 1;
    fire(6'b000010, o); check("R7 perr on target write parity", {7'b0, o[1]}, 8'h00);
    @(negedge clk); check("R7 perr one cycle", {7'b0, perr_n}, 8'h01);
    fire(6'b001000, o); check("R7 perr on read parity", {7'b0, o[1]}, 8'h00);
    check("R6 serr quiet with bit5 off", {7'b0, o[2]}, 8'h01);
    glb_par_en = 0;
    fire(6'b001010, o); check("R7 global gate off", {7'b0, o[1]}, 8'h01);
    glb_par_en = 1; wr(8'h70, 8'h00);
    fire(6'b000010, o); check("R7 local bit off", {7'b0, o[1]}, 8'h01);
    wr(8'h71, 8'hFF);
  endtask

  task automatic t_init;
    logic [2:0] o; logic [7:0] d;
    shut_init_en = 1;
    fire(6'b000001, o); check("R8 init on shutdown", {7'b0, o[0]}, 8'h00);
    @(negedge clk); check("R8 init one cycle", {7'b0, init_n}, 8'h01);
    shut_init_en = 0;
    fire(6'b000001, o); check("R8 init disabled", {7'b0, o[0]}, 8'h01);
    rd(8'h71, d); check("R8 shutdown still logged", d, 8'h01);
    wr(8'h71, 8'hFF);
  endtask

  task automatic t_tabort;
    logic [2:0] o; logic [7:0] d;
    fire(6'b100000, o); fire(6'b000010, o);
    rd(8'h71, d); check("R9 no status from abort/target parity", d, 8'h00);
  endtask

  task automatic t_other;
    logic [7:0] d;
    wr(8'h70, 8'hA8);
    fire(6'b000100, d[2:0]);
    wr(8'h72, 8'hFF); wr(8'h6F, 8'h00);
    rd(8'h72, d); check("R10 unmapped reads zero", d, 8'h00);
    rd(8'h70, d); check("R10 cmd untouched", d, 8'hA8);
    rd(8'h71, d); check("R10 sts untouched", d, 8'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    t_reset;
    t_cmd_rw;
    t_status;
    t_w1c;
    t_collide;
    t_serr;
    t_perr;
    t_init;
    t_tabort;
    t_other;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule